// File: doc/BRIEF.md
# USB Bus-Event Interrupt Controller

This block watches the decoded USB line state and a start-of-frame strobe from a packet decoder. From them it derives four bus events: suspend, meaning the bus has idled long enough; wake-up, meaning line activity appeared while the bus was suspended; end of bus reset; and start of frame. Each event sets a sticky flag in an 8-bit status register. Software reads the flags and clears them with write-zero-to-clear writes over a small register bus.

A second 8-bit register holds one enable bit per flag. The interrupt output is the registered OR of every flag that is both set and enabled. A free-running prescaler turns the system clock into a 1 µs tick. The idle timer and the reset-length timer count that tick, so suspend and reset detection do not depend on the system clock frequency.

Top module: `usb_bus_evt_irq`

## Requirements
- R1: After reset the status register reads 0x00, the enable register reads 0x00 and `irq` is 0.
- R2: Only bits 0, 3, 4 and 5 of either register are implemented. Bits 7, 6, 2 and 1 always read 0, and writes to them have no effect.
- R3: Status bit 0 (suspend) sets once the line state has been J (`line_st` = 2'b01) continuously for IDLE_TICKS ticks. It sets only once per unbroken idle stretch, even if software clears it while the line stays J.
- R4: Any line state other than J restarts the idle count from zero, so a J stretch that is interrupted does not accumulate toward suspend.
- R5: Status bit 5 (wake-up) sets only while the block is suspended and the line state is not J. Non-J activity while not suspended leaves it at 0. A wake-up event leaves the suspended state.
- R6: SE0 (`line_st` = 2'b00) held for at least RST_TICKS ticks is a bus reset. The first cycle in which the line leaves SE0 after a bus reset sets status bit 4 (end of reset) and leaves the suspended state. A shorter SE0 pulse does not set bit 4.
- R7: Each cycle with `sof_det` high sets status bit 3 (start of frame).
- R8: Flags stay set until software writes 0 to that bit of the status register (`reg_addr` = 0). Writing 1 to a bit leaves it unchanged. When a hardware set and a software clear land in the same cycle, the flag ends up set.
- R9: `irq` is high exactly one cycle after a cycle in which some status bit and its matching enable bit are both 1, and low otherwise.
- R10: `reg_addr` = 0 selects the status register and `reg_addr` = 1 selects the enable register. `reg_rdata` shows the selected register in the same cycle, and a write to the enable register replaces all of its implemented bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_st | input | 2 | Decoded line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| sof_det | input | 1 | One-cycle strobe for each detected SOF PID |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
A condition seen on the inputs at a clock edge shows in `reg_rdata` after that same edge, so a flag is visible one cycle after its cause. `irq` follows the flags one edge later, two cycles after the cause. The bench's reference model updates on the same edge as the design and compares `reg_rdata` and `irq` at the next falling edge, so each result is sampled in the cycle it is due. Inputs change just after a rising edge, which keeps them stable around the edge that samples them. The bench sets the tick to one per clock so that the idle and reset windows stay short.

// File: rtl/usb_bus_evt_irq.sv
module usb_bus_evt_irq #(
  parameter int TICK_DIV   = 48,
  parameter int IDLE_TICKS = 3000,
  parameter int RST_TICKS  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_st,
  input  logic       sof_det,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [7:0] IMPL   = 8'h39;
  localparam int IW = $clog2(IDLE_TICKS + 1);
  localparam int RW = $clog2(RST_TICKS + 1);

  logic          tick;
  logic [IW-1:0] idle_q;
  logic          fired_q;
  logic [RW-1:0] se0_q;
  logic          susp_q;
  logic [7:0]    stat_q, en_q;
  logic          irq_q;

  generate
    if (TICK_DIV > 1) begin : g_pre
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre_q;
      assign tick = (pre_q == PW'(TICK_DIV - 1));
      always_ff @(posedge clk)
        if (!rst_n || tick) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  wire is_j     = (line_st == LS_J);
  wire is_se0   = (line_st == LS_SE0);
  wire susp_set = is_j && tick && !fired_q && (idle_q == IW'(IDLE_TICKS - 1));
  wire eor_set  = !is_se0 && (se0_q == RW'(RST_TICKS));
  wire wake_set = susp_q && !is_j;

  wire [7:0] set_vec = {2'b00, wake_set, eor_set, sof_det, 2'b00, susp_set};
  wire [7:0] clr_vec = (reg_wr && !reg_addr) ? (~reg_wdata & IMPL) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q  <= '0;
      fired_q <= 1'b0;
    end else if (!is_j) begin
      idle_q  <= '0;
      fired_q <= 1'b0;
    end else if (susp_set) begin
      fired_q <= 1'b1;
    end else if (tick && !fired_q) begin
      idle_q  <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !is_se0)                     se0_q <= '0;
    else if (tick && se0_q != RW'(RST_TICKS))  se0_q <= se0_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    susp_q <= 1'b0;
    else if (susp_set)             susp_q <= 1'b1;
    else if (wake_set || eor_set)  susp_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 8'h00;
      en_q   <= 8'h00;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= set_vec | (stat_q & ~clr_vec);
      if (reg_wr && reg_addr) en_q <= reg_wdata & IMPL;
      irq_q  <= |(stat_q & en_q);
    end
  end

  assign reg_rdata = reg_addr ? en_q : stat_q;
  assign irq       = irq_q;
endmodule

// File: rtl/usb_bus_evt_irq_chk.sv
module usb_bus_evt_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sof_det,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       irq,
  input logic [7:0] stat_q,
  input logic [7:0] en_q,
  input logic       susp_q
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 8'hC6) == 8'h00); // R2
  AST_SOF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    sof_det |=> stat_q[3]); // R7
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!susp_q && !stat_q[5] && !(reg_wr && reg_addr)) |=> !stat_q[5]); // R5
  AST_SUSP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[0] && !(reg_wr && !reg_addr && !reg_wdata[0])) |=> stat_q[0]); // R8
  AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & en_q)) |=> irq); // R9
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & en_q) == 8'h00) |=> !irq); // R9
endmodule

bind usb_bus_evt_irq usb_bus_evt_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof_det(sof_det), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq(irq), .stat_q(stat_q), .en_q(en_q), .susp_q(susp_q)
);

// File: tb/usb_bus_evt_irq_tb_top.sv
`timescale 1ns/1ps
module usb_bus_evt_irq_tb_top;
  localparam int IDLE = 20;
  localparam int RSTT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] line_st = 2'b01;
  logic sof_det = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq;

  always #2.5 clk = ~clk;

  usb_bus_evt_irq #(.TICK_DIV(1), .IDLE_TICKS(IDLE), .RST_TICKS(RSTT)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_st(line_st), .sof_det(sof_det),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference model
  int m_idle = 0, m_se0 = 0;
  bit m_fired = 0, m_susp = 0, m_irq = 0;
  bit [7:0] m_st = 0, m_en = 0;

  always @(posedge clk) begin
    bit ss, es, ws;
    bit [7:0] nst;
    if (!rst_n) begin
      m_idle = 0; m_se0 = 0; m_fired = 0; m_susp = 0; m_irq = 0; m_st = 0; m_en = 0;
    end else begin
      ss = (line_st == 2'b01) && !m_fired && (m_idle == IDLE - 1);
      es = (line_st != 2'b00) && (m_se0 >= RSTT);
      ws = m_susp && (line_st != 2'b01);
      nst = m_st;
      if (reg_wr && !reg_addr)
        for (int b = 0; b < 8; b++) if (!reg_wdata[b]) nst[b] = 1'b0;
      if (ss) nst[0] = 1; if (sof_det) nst[3] = 1;
      if (es) nst[4] = 1; if (ws) nst[5] = 1;
      nst = nst & 8'h39;
      m_irq = (m_st & m_en) != 0;
      m_st = nst;
      if (reg_wr && reg_addr) m_en = reg_wdata & 8'h39;
      if (line_st != 2'b01) begin m_idle = 0; m_fired = 0; end
      else if (ss) m_fired = 1;
      else if (!m_fired) m_idle++;
      if (line_st == 2'b00) begin if (m_se0 < RSTT) m_se0++; end
      else m_se0 = 0;
      if (ss) m_susp = 1; else if (ws || es) m_susp = 0;
    end
  end

  task automatic chk(string t, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk({tag, " rdata"}, reg_rdata, reg_addr ? m_en : m_st);
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, m_irq});
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic line(logic [1:0] v, int n);
    line_st = v; step(n);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; step(1);
    reg_wr = 0; reg_addr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    step(3);
    @(negedge clk);
    chk("R1 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1; step(1);
    @(negedge clk);
    chk("R1 status after reset", reg_rdata, 8'h00);
    @(posedge clk); #1;
    tag = "R10"; reg_addr = 1; step(1);
    @(negedge clk); chk("R1 enable after reset", reg_rdata, 8'h00);
    @(posedge clk); #1; reg_addr = 0;
    tag = "R2"; wr(1, 8'hFF); reg_addr = 1; step(1);
    @(negedge clk); chk("R2 enable reserved", reg_rdata, 8'h39);
    @(posedge clk); #1; reg_addr = 0;
    tag = "R3"; line(2'b01, IDLE + 2);
    @(negedge clk); chk("R3 suspend set", reg_rdata, 8'h01);
    @(posedge clk); #1;
    tag = "R8"; wr(0, 8'hFF); step(2); wr(0, 8'hFE);
    tag = "R3"; line(2'b01, IDLE + 5);
    @(negedge clk); chk("R3 no refire while J", reg_rdata, 8'h00);
    @(posedge clk); #1;
    tag = "R5"; line(2'b10, 1); line(2'b01, 2);
    @(negedge clk); chk("R5 wake set", reg_rdata & 8'h20, 8'h20);
    @(posedge clk); #1;
    wr(0, 8'h00); line(2'b10, 3); line(2'b01, 3);
    @(negedge clk); chk("R5 no wake when awake", reg_rdata, 8'h00);
    @(posedge clk); #1;
    tag = "R4"; line(2'b01, IDLE - 5); line(2'b11, 1); line(2'b01, IDLE - 5);
    @(negedge clk); chk("R4 timer restarted", reg_rdata, 8'h00);
    @(posedge clk); #1;
    line(2'b01, 10); wr(0, 8'hDE);
    tag = "R6"; line(2'b00, RSTT - 2); line(2'b01, 2);
    @(negedge clk); chk("R6 short SE0", reg_rdata & 8'h10, 8'h00);
    @(posedge clk); #1;
    wr(0, 8'h00); line(2'b01, IDLE + 2);
    line(2'b00, RSTT + 3); line(2'b01, 2);
    @(negedge clk); chk("R6 end of reset", reg_rdata & 8'h10, 8'h10);
    @(posedge clk); #1;
    wr(0, 8'h00); line(2'b10, 2);
    @(negedge clk); chk("R6 reset left suspend", reg_rdata & 8'h20, 8'h00);
    @(posedge clk); #1;
    tag = "R7"; sof_det = 1; step(1); sof_det = 0; step(1);
    @(negedge clk); chk("R7 sof set", reg_rdata, 8'h08);
    @(posedge clk); #1;
    tag = "R8"; sof_det = 1; reg_wr = 1; reg_wdata = 8'h00; step(1);
    sof_det = 0; reg_wr = 0;
    @(negedge clk); chk("R8 set beats clear", reg_rdata, 8'h08);
    @(posedge clk); #1;
    tag = "R9"; wr(1, 8'h01); step(2);
    @(negedge clk); chk("R9 masked irq", {7'd0, irq}, 8'h00);
    @(posedge clk); #1;
    wr(1, 8'h08); step(1);
    @(negedge clk); chk("R9 enabled irq", {7'd0, irq}, 8'h01);
    @(posedge clk); #1;
    wr(0, 8'h00); step(2);
    @(negedge clk); chk("R9 irq drops", {7'd0, irq}, 8'h00);
    step(2);
    finish_run();
  end
endmodule